// File: doc/BRIEF.md
# Texture Coordinate Address Unit

This unit turns texture sample coordinates into integer element indices. Each request carries three signed 16.16 fixed-point coordinates and a per-texture description: how many axes the texture has (one, two or three), the size of each axis as a power of two, whether the coordinates are normalized so that 0.0 to 1.0 covers the whole axis, and whether out-of-range values wrap around or stick to the nearest edge. For every axis the unit produces an element index. It also produces one flattened element offset, built from those indices and the programmed axis sizes.

A second kind of texture sits on plain linear memory. It is addressed in one dimension with integers only. Normalization and the edge mode do not apply to it. For this kind the index is passed through unchanged, and a flag reports whether it falls outside the bound length. The unit is a three-stage pipeline that can take a new request on every cycle. A valid bit travels alongside each request. Filtering, caching and the memory access itself belong to later blocks.

Top module: `tca_addr_unit`

## Requirements
- R1: `out_valid` repeats `in_valid` three rising clock edges later, so one request can be accepted per cycle. After reset, `out_valid`, all indices and `out_of_range` are 0.
- R2: With `norm_mode`=0, the integer position on an axis is the floor of the signed 16.16 coordinate. Negative values round toward minus infinity, so -1.5 gives -2.
- R3: With `norm_mode`=1, the coordinate is first multiplied by the axis size 2^log and then floored. For example, 0.5 on a 16-element axis gives 8.
- R4: With `wrap_mode`=1, the index is the integer position modulo the axis size, taken from the low log bits of its two's-complement value. For example, -1 gives size-1 and 37 on a 16-element axis gives 5.
- R5: With `wrap_mode`=0 (clamp), a negative position gives 0, a position at or above the axis size gives size-1, and any other position is kept.
- R6: `tex_dims` 0 or 1 selects one axis, 2 selects two axes and 3 selects three axes. Every axis beyond the selected count outputs index 0, whatever its coordinate.
- R7: `lin_idx` = `idx_x` + `idx_y`·2^`log_w` + `idx_z`·2^(`log_w`+`log_h`).
- R8: With `lin_mode`=1, `norm_mode` and `wrap_mode` are ignored. The integer part of `coord_x` is used unaltered: `lin_idx` is its two's-complement value on `lin_idx` width, and `idx_x` is its low bits. `idx_y` and `idx_z` are 0.
- R9: With `lin_mode`=1, `out_of_range` is 1 exactly when the integer part of `coord_x` is negative or not below `lin_len`. With `lin_mode`=0, `out_of_range` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present this cycle |
| lin_mode | input | 1 | 1: linear-memory texture |
| norm_mode | input | 1 | 1: coordinates normalized to the axis size |
| wrap_mode | input | 1 | 1: wrap, 0: clamp |
| tex_dims | input | 2 | Axis count (0 or 1 = one axis) |
| log_w | input | 4 | log2 of the x size (0..10) |
| log_h | input | 4 | log2 of the y size (0..10) |
| log_d | input | 4 | log2 of the z size (0..10) |
| lin_len | input | 16 | Bound length in elements for linear mode |
| coord_x | input | 32 | Signed 16.16 x coordinate |
| coord_y | input | 32 | Signed 16.16 y coordinate |
| coord_z | input | 32 | Signed 16.16 z coordinate |
| out_valid | output | 1 | Result valid |
| idx_x | output | 10 | x element index |
| idx_y | output | 10 | y element index |
| idx_z | output | 10 | z element index |
| lin_idx | output | 30 | Flattened element offset |
| out_of_range | output | 1 | Linear-mode bound violation |

## Verification
A fault in a stage register shows up on the ports exactly three edges after the request that passed through it. Because every cycle is compared against a queue-based reference, a dropped or duplicated valid is caught on the cycle it emerges. A wrong edge-mode decision or a wrong axis-count decision changes a single index and the flattened offset together, so a mismatch points to the axis involved. A linear-mode fault shows either as a changed index or as a flag that appears on a texture that is not linear.

// File: rtl/tca_pkg.sv
`timescale 1ns/1ps
package tca_pkg;

  // Per-request handling that travels down the pipeline
  typedef struct packed {
    logic       lin;
    logic       wrap;
    logic [1:0] dims;
  } tca_mode_t;

  // Number of axes actually in use
  function automatic logic [1:0] tca_axes(input tca_mode_t m);
    if (m.lin || m.dims == 2'd0) return 2'd1;
    return m.dims;
  endfunction

endpackage

// File: rtl/tca_floor.sv
`timescale 1ns/1ps
module tca_floor #(
  parameter int CW      = 32,
  parameter int FRAC_W  = 16,
  parameter int MAX_LOG = 10,
  parameter int LOGW    = 4
) (
  input  logic signed [CW-1:0]                 coord,
  input  logic        [LOGW-1:0]               log_sz,
  input  logic                                 norm,
  output logic signed [CW-FRAC_W+MAX_LOG-1:0]  ival
);
  localparam int WW = CW + MAX_LOG;
  localparam int EW = CW - FRAC_W + MAX_LOG;

  logic signed [WW-1:0] wide;

  always_comb begin
    wide = {{MAX_LOG{coord[CW-1]}}, coord};
    if (norm) wide = wide <<< log_sz;
    ival = EW'(wide >>> FRAC_W);
  end
endmodule

// File: rtl/tca_bound.sv
`timescale 1ns/1ps
module tca_bound #(
  parameter int EW    = 26,
  parameter int IDX_W = 10,
  parameter int LOGW  = 4
) (
  input  logic signed [EW-1:0]  ival,
  input  logic        [LOGW-1:0] log_sz,
  input  logic                  wrap,
  input  logic                  active,
  output logic        [IDX_W-1:0] idx
);
  logic [EW-1:0] mask;
  logic [EW-1:0] res;

  always_comb begin
    mask = ~({EW{1'b1}} << log_sz);
    if (!active)                   res = '0;
    else if (wrap)                 res = ival & mask;
    else if (ival < 0)             res = '0;
    else if ((ival & ~mask) != '0) res = mask;
    else                           res = ival;
    idx = IDX_W'(res);
  end
endmodule

// File: rtl/tca_flatten.sv
`timescale 1ns/1ps
module tca_flatten #(
  parameter int IDX_W = 10,
  parameter int LOGW  = 4,
  parameter int LIN_W = 30
) (
  input  logic [IDX_W-1:0] x,
  input  logic [IDX_W-1:0] y,
  input  logic [IDX_W-1:0] z,
  input  logic [LOGW-1:0]  log_x,
  input  logic [LOGW-1:0]  log_y,
  output logic [LIN_W-1:0] lin
);
  logic [LOGW:0] sh_z;

  always_comb begin
    sh_z = {1'b0, log_x} + {1'b0, log_y};
    lin  = LIN_W'(x) + (LIN_W'(y) << log_x) + (LIN_W'(z) << sh_z);
  end
endmodule

// File: rtl/tca_addr_unit.sv
`timescale 1ns/1ps
module tca_addr_unit
  import tca_pkg::*;
#(
  parameter int CW      = 32,
  parameter int FRAC_W  = 16,
  parameter int MAX_LOG = 10,
  parameter int LEN_W   = 16,
  parameter int LOGW    = $clog2(MAX_LOG + 1),
  parameter int IDX_W   = MAX_LOG,
  parameter int LIN_W   = 3 * MAX_LOG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             lin_mode,
  input  logic             norm_mode,
  input  logic             wrap_mode,
  input  logic [1:0]       tex_dims,
  input  logic [LOGW-1:0]  log_w,
  input  logic [LOGW-1:0]  log_h,
  input  logic [LOGW-1:0]  log_d,
  input  logic [LEN_W-1:0] lin_len,
  input  logic [CW-1:0]    coord_x,
  input  logic [CW-1:0]    coord_y,
  input  logic [CW-1:0]    coord_z,
  output logic             out_valid,
  output logic [IDX_W-1:0] idx_x,
  output logic [IDX_W-1:0] idx_y,
  output logic [IDX_W-1:0] idx_z,
  output logic [LIN_W-1:0] lin_idx,
  output logic             out_of_range
);
  localparam int AXES = 3;
  localparam int EW   = CW - FRAC_W + MAX_LOG;

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // ---------------- stage 1: integer position per axis ----------------
  logic        [CW-1:0]   coord_in [AXES];
  logic        [LOGW-1:0] log_in   [AXES];
  logic signed [EW-1:0]   e_n      [AXES];
  logic signed [EW-1:0]   e1_q     [AXES];
  logic        [LOGW-1:0] log1_q   [AXES];
  tca_mode_t              mode_in, mode1_q;
  logic        [LEN_W-1:0] len1_q;
  logic                   v1_q;

  assign coord_in[0] = coord_x;
  assign coord_in[1] = coord_y;
  assign coord_in[2] = coord_z;
  assign log_in[0]   = log_w;
  assign log_in[1]   = log_h;
  assign log_in[2]   = log_d;
  assign mode_in     = '{lin: lin_mode, wrap: wrap_mode, dims: tex_dims};

  for (genvar a = 0; a < AXES; a++) begin : g_floor
    tca_floor #(.CW(CW), .FRAC_W(FRAC_W), .MAX_LOG(MAX_LOG), .LOGW(LOGW)) u_floor (
      .coord  (coord_in[a]),
      .log_sz (log_in[a]),
      .norm   (norm_mode & ~lin_mode),
      .ival   (e_n[a])
    );
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      v1_q    <= 1'b0;
      mode1_q <= '0;
      len1_q  <= '0;
      for (int a = 0; a < AXES; a++) begin
        e1_q[a]   <= '0;
        log1_q[a] <= '0;
      end
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        mode1_q <= mode_in;
        len1_q  <= lin_len;
        for (int a = 0; a < AXES; a++) begin
          e1_q[a]   <= e_n[a];
          log1_q[a] <= log_in[a];
        end
      end
    end
  end

  // ---------------- stage 2: edge handling and bound check ----------------
  logic [1:0]       axes1;
  logic [IDX_W-1:0] bidx   [AXES];
  logic [IDX_W-1:0] idx2_n [AXES];
  logic [IDX_W-1:0] idx2_q [AXES];
  logic             oor_n, oor2_q, v2_q, lin2_q, wrap2_q;
  logic [1:0]       dims2_q;
  logic [LOGW-1:0]  logx2_q, logy2_q;
  logic signed [EW-1:0] raw2_q;

  assign axes1 = tca_axes(mode1_q);

  for (genvar a = 0; a < AXES; a++) begin : g_bound
    tca_bound #(.EW(EW), .IDX_W(IDX_W), .LOGW(LOGW)) u_bound (
      .ival   (e1_q[a]),
      .log_sz (log1_q[a]),
      .wrap   (mode1_q.wrap),
      .active (!mode1_q.lin && (a < int'(axes1))),
      .idx    (bidx[a])
    );
  end

  always_comb begin
    for (int a = 0; a < AXES; a++) idx2_n[a] = bidx[a];
    if (mode1_q.lin) idx2_n[0] = IDX_W'(e1_q[0]);
    oor_n = mode1_q.lin &&
            ((e1_q[0] < 0) || (e1_q[0] >= $signed({1'b0, len1_q})));
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      v2_q    <= 1'b0;
      lin2_q  <= 1'b0;
      wrap2_q <= 1'b0;
      dims2_q <= '0;
      logx2_q <= '0;
      logy2_q <= '0;
      raw2_q  <= '0;
      oor2_q  <= 1'b0;
      for (int a = 0; a < AXES; a++) idx2_q[a] <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        lin2_q  <= mode1_q.lin;
        wrap2_q <= mode1_q.wrap;
        dims2_q <= mode1_q.dims;
        logx2_q <= log1_q[0];
        logy2_q <= log1_q[1];
        raw2_q  <= e1_q[0];
        oor2_q  <= oor_n;
        for (int a = 0; a < AXES; a++) idx2_q[a] <= idx2_n[a];
      end
    end
  end

  // ---------------- stage 3: flattening ----------------
  logic [LIN_W-1:0] flat, lin_n;

  tca_flatten #(.IDX_W(IDX_W), .LOGW(LOGW), .LIN_W(LIN_W)) u_flat (
    .x     (idx2_q[0]),
    .y     (idx2_q[1]),
    .z     (idx2_q[2]),
    .log_x (logx2_q),
    .log_y (logy2_q),
    .lin   (flat)
  );

  assign lin_n = lin2_q ? LIN_W'(raw2_q) : flat;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      out_valid    <= 1'b0;
      idx_x        <= '0;
      idx_y        <= '0;
      idx_z        <= '0;
      lin_idx      <= '0;
      out_of_range <= 1'b0;
    end else begin
      out_valid <= v2_q;
      if (v2_q) begin
        idx_x        <= idx2_q[0];
        idx_y        <= idx2_q[1];
        idx_z        <= idx2_q[2];
        lin_idx      <= lin_n;
        out_of_range <= oor2_q;
      end
    end
  end

  // ---------------- assertions ----------------
  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    v2_q |=> out_valid);
  // R1
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !v2_q |=> !out_valid);
  // R5
  clamp_limit_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (v2_q && !lin2_q && !wrap2_q) |-> ((IDX_W+1)'(idx2_q[0]) < ((IDX_W+1)'(1) << logx2_q)));
  // R4
  wrap_limit_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (v2_q && !lin2_q && wrap2_q) |-> ((idx2_q[0] >> logx2_q) == '0));
  // R6
  unused_axis_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (v2_q && (lin2_q || dims2_q < 2'd2)) |-> (idx2_q[1] == '0 && idx2_q[2] == '0));
  // R9
  oor_linear_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && out_of_range) |-> $past(lin2_q));
endmodule

// File: tb/sim_tca_addr_unit.sv
`timescale 1ns/1ps
module sim_tca_addr_unit;
  localparam int IDX_W = 10;
  localparam int LIN_W = 30;
  localparam int ONE   = 65536;

  typedef struct {
    bit     v;
    int     ix, iy, iz;
    longint lin;
    bit     oor;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, in_valid, lin_mode, norm_mode, wrap_mode;
  logic [1:0]  tex_dims;
  logic [3:0]  log_w, log_h, log_d;
  logic [15:0] lin_len;
  logic [31:0] coord_x, coord_y, coord_z;
  logic        out_valid, out_of_range;
  logic [IDX_W-1:0] idx_x, idx_y, idx_z;
  logic [LIN_W-1:0] lin_idx;

  tca_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lin_mode(lin_mode),
    .norm_mode(norm_mode), .wrap_mode(wrap_mode), .tex_dims(tex_dims),
    .log_w(log_w), .log_h(log_h), .log_d(log_d), .lin_len(lin_len),
    .coord_x(coord_x), .coord_y(coord_y), .coord_z(coord_z),
    .out_valid(out_valid), .idx_x(idx_x), .idx_y(idx_y), .idx_z(idx_z),
    .lin_idx(lin_idx), .out_of_range(out_of_range)
  );

  int    errors = 0;
  int    checks = 0;
  int    cyc    = 0;
  string cur_req = "R1";
  exp_t  pipe[3];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic exp_t model(bit v, bit lm, bit nm, bit wm, int dims,
                                 int lx, int ly, int lz, int len,
                                 int cx, int cy, int cz);
    exp_t   r;
    longint f, sz;
    int     lg[3];
    int     c[3];
    int     ix[3];
    int     d;
    r.v = v; r.oor = 0; r.lin = 0;
    lg[0] = lx; lg[1] = ly; lg[2] = lz;
    c[0] = cx; c[1] = cy; c[2] = cz;
    ix[0] = 0; ix[1] = 0; ix[2] = 0;
    if (lm) begin
      f     = longint'(cx) >>> 16;
      ix[0] = int'(f & ((64'sd1 << IDX_W) - 1));
      r.lin = f & ((64'sd1 << LIN_W) - 1);
      r.oor = (f < 0) || (f >= len);
    end else begin
      d = (dims < 2) ? 1 : dims;
      for (int a = 0; a < 3; a++) begin
        if (a < d) begin
          f = longint'(c[a]);
          if (nm) f = f * (64'sd1 << lg[a]);
          f  = f >>> 16;
          sz = 64'sd1 << lg[a];
          if (wm)          ix[a] = int'(f & (sz - 1));
          else if (f < 0)  ix[a] = 0;
          else if (f >= sz) ix[a] = int'(sz - 1);
          else             ix[a] = int'(f);
        end
      end
      r.lin = longint'(ix[0]) + longint'(ix[1]) * (64'sd1 << lx)
            + longint'(ix[2]) * (64'sd1 << (lx + ly));
    end
    r.ix = ix[0]; r.iy = ix[1]; r.iz = ix[2];
    return r;
  endfunction

  task automatic compare();
    exp_t e;
    e = pipe[2];
    checks++;
    if (out_valid !== e.v) begin
      errors++;
      $display("FAIL R1 out_valid: actual=%0b expected=%0b", out_valid, e.v);
    end
    if (e.v) begin
      checks++;
      if (int'(idx_x) != e.ix || int'(idx_y) != e.iy || int'(idx_z) != e.iz ||
          longint'(lin_idx) != e.lin || out_of_range !== e.oor) begin
        errors++;
        $display("FAIL %s: actual=(%0d,%0d,%0d) lin=%0d oor=%0b expected=(%0d,%0d,%0d) lin=%0d oor=%0b",
                 cur_req, idx_x, idx_y, idx_z, lin_idx, out_of_range,
                 e.ix, e.iy, e.iz, e.lin, e.oor);
      end
    end
  endtask

  task automatic apply(bit v, bit lm, bit nm, bit wm, int dims,
                       int lx, int ly, int lz, int len,
                       int cx, int cy, int cz);
    @(negedge clk);
    compare();
    pipe[2] = pipe[1];
    pipe[1] = pipe[0];
    in_valid = v; lin_mode = lm; norm_mode = nm; wrap_mode = wm;
    tex_dims = 2'(dims); log_w = 4'(lx); log_h = 4'(ly); log_d = 4'(lz);
    lin_len = 16'(len);
    coord_x = cx; coord_y = cy; coord_z = cz;
    pipe[0] = model(v, lm, nm, wm, dims, lx, ly, lz, len, cx, cy, cz);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) apply(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) pipe[i] = '{v: 0, ix: 0, iy: 0, iz: 0, lin: 0, oor: 0};
    rst_n = 1'b0; in_valid = 0; lin_mode = 0; norm_mode = 0; wrap_mode = 0;
    tex_dims = 0; log_w = 0; log_h = 0; log_d = 0; lin_len = 0;
    coord_x = 0; coord_y = 0; coord_z = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 0 || idx_x !== 0 || idx_y !== 0 || idx_z !== 0 ||
        lin_idx !== 0 || out_of_range !== 0) begin
      errors++;
      $display("FAIL R1 reset state: actual valid=%0b lin=%0d expected valid=0 lin=0",
               out_valid, lin_idx);
    end

    // R2: floor of unnormalized coordinates, including negatives
    cur_req = "R2";
    apply(1, 0, 0, 0, 1, 4, 0, 0, 0, 3 * ONE + ONE / 2, 0, 0);
    apply(1, 0, 0, 1, 1, 4, 0, 0, 0, -(ONE + ONE / 2), 0, 0);
    apply(1, 0, 0, 1, 2, 4, 3, 0, 0, 5 * ONE + 3 * ONE / 4, -(ONE / 4), 0);
    idle(1);

    // R3: normalized coordinates scaled by the axis size
    cur_req = "R3";
    apply(1, 0, 1, 0, 1, 4, 0, 0, 0, ONE / 2, 0, 0);
    apply(1, 0, 1, 1, 1, 4, 0, 0, 0, ONE, 0, 0);
    apply(1, 0, 1, 0, 1, 4, 0, 0, 0, ONE, 0, 0);
    apply(1, 0, 1, 0, 1, 4, 0, 0, 0, -655, 0, 0);
    apply(1, 0, 1, 1, 2, 3, 5, 0, 0, 3 * ONE / 4, ONE / 3, 0);

    // R4: wrap by modulo on the axis size
    cur_req = "R4";
    apply(1, 0, 0, 1, 1, 4, 0, 0, 0, 37 * ONE, 0, 0);
    apply(1, 0, 0, 1, 1, 4, 0, 0, 0, -17 * ONE, 0, 0);
    apply(1, 0, 0, 1, 1, 0, 0, 0, 0, 9 * ONE, 0, 0);

    // R5: clamp to the boundary elements
    cur_req = "R5";
    apply(1, 0, 0, 0, 1, 4, 0, 0, 0, 100 * ONE, 0, 0);
    apply(1, 0, 0, 0, 1, 4, 0, 0, 0, -3 * ONE, 0, 0);
    apply(1, 0, 0, 0, 1, 4, 0, 0, 0, 15 * ONE, 0, 0);
    apply(1, 0, 0, 0, 1, 4, 0, 0, 0, 16 * ONE, 0, 0);

    // R6: axes beyond the dimension count give 0
    cur_req = "R6";
    apply(1, 0, 0, 0, 1, 3, 3, 3, 0, 2 * ONE, 3 * ONE, 2 * ONE);
    apply(1, 0, 0, 0, 0, 3, 3, 3, 0, 2 * ONE, 3 * ONE, 2 * ONE);
    apply(1, 0, 0, 0, 2, 3, 3, 3, 0, 2 * ONE, 3 * ONE, 2 * ONE);
    apply(1, 0, 0, 0, 3, 3, 3, 3, 0, 2 * ONE, 3 * ONE, 2 * ONE);

    // R7: flattened offset from three axes
    cur_req = "R7";
    apply(1, 0, 0, 0, 3, 2, 3, 1, 0, 3 * ONE, 5 * ONE, ONE);
    apply(1, 0, 0, 1, 3, 10, 10, 10, 0, 1023 * ONE, 1023 * ONE, 1023 * ONE);

    // R8: linear-memory mode ignores normalization and edge mode
    cur_req = "R8";
    apply(1, 1, 1, 1, 3, 2, 2, 2, 1000, 700 * ONE + 5, 4 * ONE, 4 * ONE);
    apply(1, 1, 0, 0, 1, 0, 0, 0, 40000, 32000 * ONE, 0, 0);

    // R9: bound check only in linear-memory mode
    cur_req = "R9";
    apply(1, 1, 0, 0, 1, 0, 0, 0, 1000, 1000 * ONE, 0, 0);
    apply(1, 1, 0, 0, 1, 0, 0, 0, 1000, 999 * ONE, 0, 0);
    apply(1, 1, 0, 1, 1, 0, 0, 0, 1000, -(ONE / 2), 0, 0);
    apply(1, 0, 0, 1, 1, 2, 0, 0, 0, -5 * ONE, 0, 0);
    idle(2);

    // R1 and all: random stream with bubbles
    cur_req = "R1";
    for (int i = 0; i < 3000; i++) begin
      int lx, ly, lz, span;
      lx = $urandom_range(0, 6); ly = $urandom_range(0, 6); lz = $urandom_range(0, 6);
      span = 200 * ONE;
      apply($urandom_range(0, 9) < 7, $urandom_range(0, 4) == 0, $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 3), lx, ly, lz,
            $urandom_range(0, 300),
            int'($urandom_range(0, 2 * span)) - span,
            int'($urandom_range(0, 2 * span)) - span,
            int'($urandom_range(0, 2 * span)) - span);
    end
    idle(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule